// File: doc/BRIEF.md
# Ordered Store Commit Queue with Line Ownership

This block sits between a core's retirement stage and its private data cache. Retired stores are queued in a small ring and leave it strictly oldest first. The oldest entry may be written into the cache only while its line is held with write permission (Modified or Exclusive). When the cache's state lookup says the line is not held, the block raises one ownership request for that entry alone. It then waits for the grant and for every invalidation acknowledgement the grant announces, and only then performs the write.

Queuing a store sends nothing to the coherence side. Other cores keep reading the old line contents until the oldest entry actually commits. From the grant until the write cycle the block raises a line-hold output, so the cache can refuse snoops on that line. A drain input blocks new stores and reports when the queue has emptied.

Top module: `store_commit_queue`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `full`=0), and `wr_valid`, `rfo_req`, `hold_line` and `drained` are all 0.
- R2: Cache writes leave in enqueue order. A younger store whose line is held is not written while an older store is still waiting for ownership.
- R3: When the oldest entry's line is reported held (`lk_owned`=1 for `lk_addr`), that entry is written (`wr_valid`=1 with its address, data and byte mask) in the first cycle it is oldest, with no ownership request.
- R4: When the oldest entry's line is not held, `rfo_req` is raised with `rfo_addr` equal to that entry's address and stays high with a stable address until `rfo_grant`. Only one request is ever outstanding.
- R5: After a request, the write happens only once `rfo_grant` has been seen and the number of `inv_ack` pulses equals the `rfo_acks` value given with the grant. Until then `wr_valid` stays 0 and the cache is not touched. The write follows in the second cycle after the last of these events.
- R6: `hold_line` is 1 from the cycle after the grant through the cycle of the write, and falls only after a write.
- R7: With DEPTH entries queued, `full`=1 and `enq_stall`=1, and a further store is refused and never reaches the cache.
- R8: While `drain_req`=1, `enq_stall`=1 and offered stores are refused. `drained`=1 exactly when `drain_req`=1 and the queue is empty.
- R9: An enqueue and a commit in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Retired store offered |
| enq_addr | input | AW | Store address |
| enq_data | input | DW | Store data |
| enq_mask | input | DW/8 | Byte enables |
| enq_stall | output | 1 | Store refused this cycle (full or draining) |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entries held |
| drain_req | input | 1 | Request to empty the queue |
| drained | output | 1 | Drain requested and queue empty |
| lk_addr | output | AW | Address of the oldest entry, for the line-state lookup |
| lk_owned | input | 1 | Line of `lk_addr` is Modified or Exclusive |
| wr_valid | output | 1 | Cache write of the oldest entry this cycle |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_mask | output | DW/8 | Write byte enables |
| rfo_req | output | 1 | Ownership request pending |
| rfo_addr | output | AW | Address being requested |
| rfo_grant | input | 1 | Ownership granted (one-cycle pulse) |
| rfo_acks | input | ACK_W | Invalidation acknowledgements to expect, valid with the grant |
| inv_ack | input | 1 | One invalidation acknowledgement |
| hold_line | output | 1 | Keep the line from snoops until the write is done |

## Verification
The collision of interest is a new store being accepted in the same cycle that the oldest entry is written to the cache. The bench provokes it by streaming back-to-back stores to lines reported as held, so each commit overlaps the next enqueue. It judges the outcome by three results: the overlap was seen at the ports, every store reached the cache in order with its own data, and the queue ended empty. A second overlap, between ownership waiting and younger held lines, is judged by `wr_valid` staying low until the older store's acknowledgements are complete.

// File: rtl/sbo_pkg.sv
package sbo_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE   = 2'd0,
      OWN_REQ    = 2'd1,
      OWN_ACKW   = 2'd2,
      OWN_COMMIT = 2'd3
   } own_st_e;
endpackage

// File: rtl/sbo_ring.sv
module sbo_ring #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head_data,
   output logic             empty,
   output logic             full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] slot [DEPTH];
   logic [PW-1:0]    wp, rp;
   logic [CW-1:0]    cnt;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) slot[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= step(wp);
         if (pop)  rp <= step(rp);
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign head_data = slot[rp];
   assign empty     = (cnt == '0);
   assign full      = (cnt == CW'(DEPTH));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R2
endmodule

// File: rtl/sbo_own_ctl.sv
module sbo_own_ctl
   import sbo_pkg::*;
#(
   parameter int ACK_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             head_valid,
   input  logic             lk_owned,
   input  logic             rfo_grant,
   input  logic [ACK_W-1:0] rfo_acks,
   input  logic             inv_ack,
   output logic             rfo_req,
   output logic             hold_line,
   output logic             commit
);
   own_st_e          st, st_nx;
   logic [ACK_W-1:0] need, got;

   always_comb begin
      st_nx = st;
      case (st)
         OWN_IDLE:   if (head_valid && !lk_owned) st_nx = OWN_REQ;
         OWN_REQ:    if (rfo_grant) st_nx = OWN_ACKW;
         OWN_ACKW:   if (got == need) st_nx = OWN_COMMIT;
         OWN_COMMIT: st_nx = OWN_IDLE;
         default:    st_nx = OWN_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= OWN_IDLE;
         need <= '0;
         got  <= '0;
      end else begin
         st <= st_nx;
         if (st == OWN_REQ && rfo_grant) need <= rfo_acks;
         if (st == OWN_IDLE || st == OWN_COMMIT) got <= '0;
         else if (inv_ack) got <= got + 1'b1;
      end
   end

   assign rfo_req   = (st == OWN_REQ);
   assign hold_line = (st == OWN_ACKW) || (st == OWN_COMMIT);
   assign commit    = (st == OWN_COMMIT) ||
                      (st == OWN_IDLE && head_valid && lk_owned);

   AST_HOLD_TO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_line) |-> $past(commit)); // R6
   AST_REQ_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      rfo_req |-> head_valid); // R4
endmodule

// File: rtl/store_commit_queue.sv
module store_commit_queue #(
   parameter int AW    = 32,
   parameter int DW    = 64,
   parameter int DEPTH = 8,
   parameter int ACK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   input  logic [AW-1:0]     enq_addr,
   input  logic [DW-1:0]     enq_data,
   input  logic [DW/8-1:0]   enq_mask,
   output logic              enq_stall,
   output logic              full,
   output logic              empty,
   input  logic              drain_req,
   output logic              drained,
   output logic [AW-1:0]     lk_addr,
   input  logic              lk_owned,
   output logic              wr_valid,
   output logic [AW-1:0]     wr_addr,
   output logic [DW-1:0]     wr_data,
   output logic [DW/8-1:0]   wr_mask,
   output logic              rfo_req,
   output logic [AW-1:0]     rfo_addr,
   input  logic              rfo_grant,
   input  logic [ACK_W-1:0]  rfo_acks,
   input  logic              inv_ack,
   output logic              hold_line
);
   localparam int MW = DW / 8;
   localparam int EW = AW + DW + MW;

   generate
      if (DW % 8 != 0) begin : g_bad_dw
         $error("store_commit_queue: DW must be a whole number of bytes");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("store_commit_queue: DEPTH must be at least 2");
      end
      if (ACK_W < 1) begin : g_bad_ackw
         $error("store_commit_queue: ACK_W must be at least 1");
      end
   endgenerate

   logic          push, pop;
   logic [EW-1:0] head;

   assign enq_stall = full || drain_req;
   assign push      = enq_valid && !enq_stall;
   assign drained   = drain_req && empty;

   sbo_ring #(.DEPTH(DEPTH), .WIDTH(EW)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data ({enq_addr, enq_data, enq_mask}),
      .pop       (pop),
      .head_data (head),
      .empty     (empty),
      .full      (full)
   );

   sbo_own_ctl #(.ACK_W(ACK_W)) u_own (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (!empty),
      .lk_owned   (lk_owned),
      .rfo_grant  (rfo_grant),
      .rfo_acks   (rfo_acks),
      .inv_ack    (inv_ack),
      .rfo_req    (rfo_req),
      .hold_line  (hold_line),
      .commit     (pop)
   );

   assign lk_addr  = head[EW-1 -: AW];
   assign rfo_addr = head[EW-1 -: AW];
   assign wr_addr  = head[EW-1 -: AW];
   assign wr_data  = head[MW +: DW];
   assign wr_mask  = head[0 +: MW];
   assign wr_valid = pop;

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      rfo_req && $past(rfo_req) |-> $stable(rfo_addr)); // R4
   AST_NO_WRITE_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rfo_req |-> !wr_valid); // R5
endmodule

// File: tb/sim_store_commit_queue.sv
module sim_store_commit_queue;
   localparam int PER = 10;
   localparam int AW = 32, DW = 64, MW = 8, ACK_W = 4, DEPTH = 8;

   typedef struct {
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [MW-1:0] m;
   } item_t;

   logic clk = 0, rst_n = 0;
   logic enq_valid = 0;
   logic [AW-1:0] enq_addr = '0;
   logic [DW-1:0] enq_data = '0;
   logic [MW-1:0] enq_mask = '0;
   logic enq_stall, full, empty, drained, drain_req = 0;
   logic [AW-1:0] lk_addr, wr_addr, rfo_addr;
   logic lk_owned, wr_valid, rfo_req, hold_line;
   logic [DW-1:0] wr_data;
   logic [MW-1:0] wr_mask;
   logic rfo_grant = 0, inv_ack = 0;
   logic [ACK_W-1:0] rfo_acks = '0;
   logic [15:0] own_map = '0;

   int errs = 0, checks = 0, wr_cnt = 0;
   bit overlap = 0, resp_en = 0;
   int resp_acks = 0, resp_dly = 1;
   item_t exp_q[$];

   always #(PER/2) clk = ~clk;
   assign lk_owned = own_map[lk_addr[6:3]];

   store_commit_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .ACK_W(ACK_W)) u0 (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_addr(enq_addr),
      .enq_data(enq_data), .enq_mask(enq_mask), .enq_stall(enq_stall),
      .full(full), .empty(empty), .drain_req(drain_req), .drained(drained),
      .lk_addr(lk_addr), .lk_owned(lk_owned), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
      .rfo_req(rfo_req), .rfo_addr(rfo_addr), .rfo_grant(rfo_grant),
      .rfo_acks(rfo_acks), .inv_ack(inv_ack), .hold_line(hold_line));

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // Caller is at posedge+1; leaves at the next posedge+1 with enq_valid low.
   task automatic enq(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [MW-1:0] m);
      item_t it;
      enq_valid = 1; enq_addr = a; enq_data = d; enq_mask = m;
      if (!enq_stall) begin
         it.a = a; it.d = d; it.m = m;
         exp_q.push_back(it);
      end
      @(posedge clk); #1;
      enq_valid = 0;
   endtask

   task automatic wait_empty;
      @(negedge clk);
      while (!empty || wr_valid) @(negedge clk);
      @(posedge clk); #1;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && wr_valid) begin
         wr_cnt++;
         if (wr_valid && enq_valid && !enq_stall) overlap = 1;
         if (exp_q.size() == 0) begin
            chk(0, "R2", "write with nothing expected", wr_addr, 0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            chk(wr_addr == e.a, "R2", "write order addr", wr_addr, e.a);
            chk(wr_data == e.d, "R2", "write data", wr_data, e.d);
            chk(wr_mask == e.m, "R2", "write mask", 64'(wr_mask), 64'(e.m));
         end
      end
   end

   // Ownership responder
   initial begin
      forever begin
         @(negedge clk);
         if (resp_en && rfo_req) begin
            chk(exp_q.size() > 0 && rfo_addr == exp_q[0].a, "R4",
                "request addr is oldest", rfo_addr, exp_q.size() > 0 ? exp_q[0].a : 0);
            repeat (resp_dly) @(posedge clk);
            #1;
            chk(rfo_req == 1, "R4", "request held until grant", 64'(rfo_req), 1);
            rfo_grant = 1; rfo_acks = ACK_W'(resp_acks);
            @(posedge clk); #1;
            rfo_grant = 0;
            @(negedge clk);
            chk(hold_line == 1, "R6", "hold after grant", 64'(hold_line), 1);
            for (int k = 0; k < resp_acks; k++) begin
               chk(wr_valid == 0, "R5", "no write before all acks", 64'(wr_valid), 0);
               chk(hold_line == 1, "R6", "hold while acks pending", 64'(hold_line), 1);
               @(posedge clk); #1; inv_ack = 1;
               @(posedge clk); #1; inv_ack = 0;
               @(negedge clk);
            end
            chk(wr_valid == 0, "R5", "write not before second cycle", 64'(wr_valid), 0);
            @(negedge clk);
            chk(wr_valid == 1, "R5", "write after acks", 64'(wr_valid), 1);
            chk(hold_line == 1, "R6", "hold in write cycle", 64'(hold_line), 1);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "WDOG", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(empty == 1 && full == 0, "R1", "empty/full after reset", {full, empty}, 2'b01);
      chk(wr_valid == 0 && rfo_req == 0 && hold_line == 0 && drained == 0, "R1",
          "outputs idle after reset", {wr_valid, rfo_req, hold_line, drained}, 0);
      @(posedge clk); #1;

      // R3 owned head commits at once
      own_map = 16'h000F;
      enq(32'h0000_0008, 64'h1111_2222_3333_4444, 8'hF0);
      @(negedge clk);
      chk(wr_valid == 1, "R3", "owned head writes at once", 64'(wr_valid), 1);
      chk(rfo_req == 0, "R3", "no request for owned line", 64'(rfo_req), 0);
      chk(lk_addr == 32'h8, "R3", "lookup addr", lk_addr, 32'h8);
      wait_empty();

      // R2 + R4 + R5: older unowned, younger owned
      own_map = 16'h0002;
      enq(32'h0000_0040, 64'hAAAA_0000_0000_0001, 8'hFF);
      enq(32'h0000_0008, 64'hBBBB_0000_0000_0002, 8'h0F);
      repeat (4) begin
         @(negedge clk);
         chk(wr_valid == 0, "R2", "younger held line waits", 64'(wr_valid), 0);
         chk(rfo_req == 1, "R4", "request raised", 64'(rfo_req), 1);
      end
      resp_acks = 2; resp_dly = 2; resp_en = 1;
      wait_empty();
      chk(exp_q.size() == 0, "R2", "both written", exp_q.size(), 0);

      // R5 with zero acks and R6 hold release
      resp_acks = 0; resp_dly = 1; own_map = '0;
      enq(32'h0000_0050, 64'hCCCC_DDDD_EEEE_FFFF, 8'h3C);
      wait_empty();
      @(negedge clk);
      chk(hold_line == 0, "R6", "hold released after write", 64'(hold_line), 0);

      // R7 full
      @(posedge clk); #1;
      resp_en = 0; resp_acks = 3; own_map = '0;
      for (int i = 0; i < DEPTH; i++)
         enq(32'h100 + 32'(i*8), 64'hF000 + 64'(i), 8'hFF);
      @(negedge clk);
      chk(full == 1 && enq_stall == 1, "R7", "full and stall", {full, enq_stall}, 2'b11);
      @(posedge clk); #1;
      enq(32'h0000_0200, 64'hDEAD_DEAD_DEAD_DEAD, 8'hFF);
      chk(exp_q.size() == DEPTH, "R7", "extra store refused", exp_q.size(), DEPTH);
      base = wr_cnt;
      resp_en = 1;
      wait_empty();
      chk(wr_cnt - base == DEPTH, "R7", "only DEPTH writes", wr_cnt - base, DEPTH);

      // R8 drain
      resp_en = 0; resp_acks = 1;
      enq(32'h0000_0300, 64'h0101, 8'h01);
      enq(32'h0000_0308, 64'h0202, 8'h02);
      drain_req = 1;
      @(negedge clk);
      chk(enq_stall == 1 && drained == 0, "R8", "drain stalls, not drained",
          {enq_stall, drained}, 2'b10);
      @(posedge clk); #1;
      enq(32'h0000_0310, 64'h0303, 8'h04);
      chk(exp_q.size() == 2, "R8", "store refused while draining", exp_q.size(), 2);
      resp_en = 1;
      wait_empty();
      @(negedge clk);
      chk(drained == 1, "R8", "drained when empty", 64'(drained), 1);
      @(posedge clk); #1;
      drain_req = 0;
      @(negedge clk);
      chk(drained == 0, "R8", "drained follows request", 64'(drained), 0);

      // R9 enqueue and commit in one cycle
      @(posedge clk); #1;
      own_map = 16'hFFFF; overlap = 0; base = wr_cnt;
      for (int i = 0; i < 6; i++)
         enq(32'h400 + 32'(i*8), 64'h9000 + 64'(i), 8'hAA);
      wait_empty();
      chk(overlap == 1, "R9", "overlap seen", 64'(overlap), 1);
      chk(wr_cnt - base == 6, "R9", "all streamed stores written", wr_cnt - base, 6);
      chk(exp_q.size() == 0, "R9", "scoreboard drained", exp_q.size(), 0);

      repeat (3) @(posedge clk);
      finish_run();
   end
endmodule